// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block recovers asynchronous character frames from a single serial input line. It uses an oversampling clock-enable (`os_tick`) at sixteen times the bit rate. A frame starts with a falling edge that must still read low halfway through the start bit. After that, every following bit is sampled at the centre of its bit period. A configuration register sets the frame format: 7 or 8 data bits, an optional even or odd parity bit, one or two stop bits, and the bit order.

The assembled character sits in a hidden shift register until its last stop bit has been sampled. It is then copied to a readable data register and the full flag is raised. While software reads that byte, the next frame can already be shifting in. The full, overrun, framing and parity flags are set only by hardware. Software clears them by writing 0 to the matching bit of the status register, and writing 1 leaves a bit unchanged. Two interrupt request lines report a waiting character and any error flag. A single enable bit gates both lines.

The register bus is a plain select/write strobe with a 2-bit address. Writes take effect on the clock edge, and read data is combinational from the address.

Top module: `serial_rx_dbuf`

## Requirements
- R1: After reset the configuration, status and data registers read 0x00, and both interrupt lines are low.
- R2: A start bit is a high-to-low transition of the synchronised line that is still low at the 8th oversample tick. A shorter low pulse produces no character and sets no flag. Each later bit is sampled at the 16th tick after the previous sample point.
- R3: When a frame completes and the full flag (status bit 0) is 0, the character is copied to the data register (address 2) and the full flag is set.
- R4: The shift register and the data register form a double buffer. A frame arriving back-to-back with the previous one is received correctly if the earlier byte is read and its full flag cleared before the later frame completes.
- R5: When a frame completes while the full flag is 1, the overrun flag (status bit 1) is set and the data register keeps its earlier byte.
- R6: When the first stop bit samples low, the framing-error flag (status bit 2) is set.
- R7: With parity on (configuration bit 3), one parity bit follows the data. Configuration bit 4 selects the sense: 0 for even, 1 for odd. A mismatch sets the parity-error flag (status bit 3).
- R8: With configuration bit 2 set, characters have 7 data bits. They arrive in bits 6:0 of the data register with bit 7 read as 0, and are always received LSB first whatever the direction bit says.
- R9: With configuration bit 6 set and 8-bit characters, the first data bit received is stored in bit 7.
- R10: With configuration bit 5 set, a frame has two stop bits and completes only after the second one is sampled.
- R11: A write to the status register (address 1) clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. A write never sets a flag.
- R12: With configuration bit 1 set, the receive interrupt follows the full flag and the error interrupt follows the OR of the overrun, framing and parity flags. With the bit clear, both interrupts stay low.
- R13: While configuration bit 0 is 0, nothing is received and no flag changes from line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit period |
| rxd | input | 1 | Asynchronous serial line, idle high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | Register address: 0 configuration, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not selected |
| irq_rx_full | output | 1 | Character-waiting interrupt request |
| irq_rx_err | output | 1 | Receive-error interrupt request |

## Verification
The assertions assume the configuration register is written only while the line is idle. They also assume that `rxd` changes only on bit-period boundaries of exactly sixteen ticks, so the mid-bit samples never straddle a transition. The stimulus runs with `os_tick` held high, so one bit is sixteen clocks. Each frame is driven as whole bit periods, and four idle-high clocks separate frames so that every start bit is a clean falling edge. Format changes happen only after the scoreboard has drained and the monitor has gone quiet.

// File: rtl/rxdb_pkg.sv
package rxdb_pkg;

    localparam int CHAR_W = 8;

    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    // bit 0 is rx_on ... bit 6 is msb_first
    typedef struct packed {
        logic msb_first;
        logic stop2;
        logic par_odd;
        logic par_on;
        logic len7;
        logic irq_en;
        logic rx_on;
    } rx_cfg_t;

    // bit 0 full, bit 1 overrun, bit 2 framing, bit 3 parity
    typedef struct packed {
        logic par_err;
        logic frm_err;
        logic ovr;
        logic full;
    } rx_flags_t;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
    } rx_state_t;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              frm_bad;
        logic              par_bad;
    } rx_frame_t;

    function automatic logic [CHAR_W-1:0] shift_in(logic [CHAR_W-1:0] sh,
                                                   logic b, logic msb_mode);
        return msb_mode ? {sh[CHAR_W-2:0], b} : {b, sh[CHAR_W-1:1]};
    endfunction

    function automatic logic [CHAR_W-1:0] align_char(logic [CHAR_W-1:0] sh,
                                                     logic len7);
        return len7 ? {1'b0, sh[CHAR_W-1:1]} : sh;
    endfunction

endpackage

// File: rtl/rxdb_sync.sv
module rxdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rxdb_frame.sv
module rxdb_frame
    import rxdb_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      os_tick,
    input  logic      rxd,
    input  logic      rx_on,
    input  logic      len7,
    input  logic      par_on,
    input  logic      par_odd,
    input  logic      stop2,
    input  logic      msb_first,
    output logic      done,
    output rx_frame_t frame,
    output logic      busy
);
    localparam int CNT_W = $clog2(OS_RATE);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OS_RATE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OS_RATE - 1);
    localparam int BIT_W = $clog2(CHAR_W);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitn;
    logic [CHAR_W-1:0] shr;
    logic              pacc, pbad, fbad, rxd_q;

    logic             msb_mode;
    logic [BIT_W-1:0] last_bit;
    assign msb_mode = msb_first & ~len7;
    assign last_bit = len7 ? BIT_W'(CHAR_W - 2) : BIT_W'(CHAR_W - 1);
    assign busy     = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !rx_on) begin
            state <= S_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shr   <= '0;
            pacc  <= 1'b0;
            pbad  <= 1'b0;
            fbad  <= 1'b0;
            rxd_q <= 1'b1;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                rxd_q <= rxd;
                case (state)
                    S_IDLE: begin
                        if (rxd_q && !rxd) begin
                            state <= S_START;
                            cnt   <= CNT_W'(1);
                        end
                    end
                    S_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt   <= '0;
                            bitn  <= '0;
                            pacc  <= 1'b0;
                            pbad  <= 1'b0;
                            state <= rxd ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == FULL_LAST) begin
                            cnt <= '0;
                            case (state)
                                S_DATA: begin
                                    shr  <= shift_in(shr, rxd, msb_mode);
                                    pacc <= pacc ^ rxd;
                                    bitn <= bitn + 1'b1;
                                    if (bitn == last_bit)
                                        state <= par_on ? S_PAR : S_STOP1;
                                end
                                S_PAR: begin
                                    pbad  <= (pacc ^ rxd) != par_odd;
                                    state <= S_STOP1;
                                end
                                S_STOP1: begin
                                    fbad <= ~rxd;
                                    if (stop2) begin
                                        state <= S_STOP2;
                                    end else begin
                                        state <= S_IDLE;
                                        done  <= 1'b1;
                                        frame <= '{data: align_char(shr, len7),
                                                   frm_bad: ~rxd, par_bad: pbad};
                                    end
                                end
                                default: begin
                                    state <= S_IDLE;
                                    done  <= 1'b1;
                                    frame <= '{data: align_char(shr, len7),
                                               frm_bad: fbad, par_bad: pbad};
                                end
                            endcase
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rxdb_regs.sv
module rxdb_regs
    import rxdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_cfg,
    input  logic              wr_stat,
    input  logic [7:0]        wdata,
    input  logic [1:0]        rd_addr,
    input  logic              done,
    input  rx_frame_t         frame,
    output rx_cfg_t           cfg,
    output rx_flags_t         flags,
    output logic [CHAR_W-1:0] data_q,
    output logic [7:0]        rdata
);
    rx_flags_t flags_nxt;

    always_comb begin
        flags_nxt = flags & (wr_stat ? rx_flags_t'(wdata[3:0]) : rx_flags_t'(4'hF));
        if (done) begin
            if (flags.full) begin
                flags_nxt.ovr = 1'b1;
            end else begin
                flags_nxt.full    = 1'b1;
                flags_nxt.frm_err = flags_nxt.frm_err | frame.frm_bad;
                flags_nxt.par_err = flags_nxt.par_err | frame.par_bad;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            flags  <= '0;
            data_q <= '0;
        end else begin
            if (wr_cfg) cfg <= rx_cfg_t'(wdata[6:0]);
            flags <= flags_nxt;
            if (done && !flags.full) data_q <= frame.data;
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CFG:  rdata = {1'b0, cfg};
            ADDR_STAT: rdata = {4'b0, flags};
            ADDR_DATA: rdata = data_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf
    import rxdb_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_rx_full,
    output logic       irq_rx_err
);
    logic              rxd_s, rx_done, rx_busy, wr_cfg, wr_stat;
    rx_frame_t         rx_frame;
    rx_cfg_t           cfg;
    rx_flags_t         flags;
    logic [CHAR_W-1:0] data_q;
    logic [7:0]        reg_rdata;

    assign wr_cfg  = bus_sel & bus_wr & (bus_addr == ADDR_CFG);
    assign wr_stat = bus_sel & bus_wr & (bus_addr == ADDR_STAT);

    rxdb_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d(rxd), .q(rxd_s)
    );

    rxdb_frame #(.OS_RATE(OS_RATE)) frame_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd_s),
        .rx_on(cfg.rx_on), .len7(cfg.len7), .par_on(cfg.par_on),
        .par_odd(cfg.par_odd), .stop2(cfg.stop2), .msb_first(cfg.msb_first),
        .done(rx_done), .frame(rx_frame), .busy(rx_busy)
    );

    rxdb_regs regs_i (
        .clk(clk), .rst(rst), .wr_cfg(wr_cfg), .wr_stat(wr_stat),
        .wdata(bus_wdata), .rd_addr(bus_addr), .done(rx_done),
        .frame(rx_frame), .cfg(cfg), .flags(flags), .data_q(data_q),
        .rdata(reg_rdata)
    );

    assign bus_rdata   = bus_sel ? reg_rdata : 8'h00;
    assign irq_rx_full = cfg.irq_en & flags.full;
    assign irq_rx_err  = cfg.irq_en & (flags.ovr | flags.frm_err | flags.par_err);
endmodule

// File: rtl/serial_rx_dbuf_chk.sv
module serial_rx_dbuf_chk
    import rxdb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              busy,
    input logic              wr_stat,
    input rx_cfg_t           cfg,
    input rx_flags_t         flags,
    input logic [CHAR_W-1:0] data_q,
    input logic              irq_full,
    input logic              irq_err
);
    assert_full_from_frame_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.full) |-> $past(done));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_overrun_keeps_data_R5: assert property (@(posedge clk) disable iff (rst)
        (done && flags.full) |=> ($stable(data_q) && flags.ovr));

    assert_no_sw_set_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !done) |=> ((flags & ~$past(flags)) == 4'b0000));

    assert_irq_gated_R12: assert property (@(posedge clk) disable iff (rst)
        (irq_full || irq_err) |-> cfg.irq_en);

    assert_rx_off_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !cfg.rx_on |=> (!busy && !done));
endmodule

bind serial_rx_dbuf serial_rx_dbuf_chk chk_i (
    .clk(clk), .rst(rst), .done(rx_done), .busy(rx_busy), .wr_stat(wr_stat),
    .cfg(cfg), .flags(flags), .data_q(data_q),
    .irq_full(irq_rx_full), .irq_err(irq_rx_err)
);

// File: tb/serial_rx_dbuf_tb_top.sv
module serial_rx_dbuf_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_rx_full, irq_rx_err;

    always #5 clk = ~clk;

    serial_rx_dbuf dut_i (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_rx_full(irq_rx_full), .irq_rx_err(irq_rx_err)
    );

    typedef struct {
        logic [7:0] data;
        logic       fe;
        logic       pe;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    int         n_chk = 0, n_fail = 0;
    bit         mon_on = 1'b0;
    logic [7:0] cfg_v = 8'h00;

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic bus_wt(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] v);
        cfg_v = v;
        bus_wt(2'd0, v);
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    // Frame driver: pushes the expected item, then drives the line.
    task automatic send(input logic [7:0] v, input string tag,
                        input bit bad_par = 1'b0, input bit bad_stop = 1'b0,
                        input bit push = 1'b1);
        bit         len7 = cfg_v[2];
        bit         msb  = cfg_v[6] && !cfg_v[2];
        int         n    = len7 ? 7 : 8;
        logic [7:0] dm   = len7 ? (v & 8'h7F) : v;
        exp_t       e;
        e.data = dm; e.fe = bad_stop; e.pe = cfg_v[3] & bad_par; e.tag = tag;
        if (push) sb.push_back(e);
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(msb ? v[n-1-i] : v[i]);
        if (cfg_v[3]) drive_bit((^dm) ^ cfg_v[4] ^ bad_par);
        drive_bit(!bad_stop);
        if (cfg_v[5]) drive_bit(1'b1);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    // Monitor: pops one expected item per received character.
    initial begin
        logic [7:0] d, s;
        exp_t       e;
        forever begin
            @(negedge clk);
            if (mon_on && irq_rx_full) begin
                bus_rd(2'd2, d);
                bus_rd(2'd1, s);
                if (sb.size() == 0) begin
                    chk("R3 unexpected character", d, 8'hxx);
                end else begin
                    e = sb.pop_front();
                    chk({e.tag, " data"}, d, e.data);
                    chk({e.tag, " status"}, s, {4'b0, e.pe, e.fe, 1'b0, 1'b1});
                end
                bus_wt(2'd1, 8'h00);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_rd(2'd0, r); chk("R1 cfg", r, 8'h00);
        bus_rd(2'd1, r); chk("R1 status", r, 8'h00);
        bus_rd(2'd2, r); chk("R1 data", r, 8'h00);
        chk("R1 irqs", {6'b0, irq_rx_full, irq_rx_err}, 8'h00);

        // R3 basic 8N1, R4 back-to-back frames
        set_cfg(8'h03);
        mon_on = 1'b1;
        send(8'hA5, "R3");
        send(8'h3C, "R3");
        send(8'h55, "R4");
        send(8'h0F, "R4");
        send(8'hF0, "R4");
        drain();

        // R9 MSB first
        set_cfg(8'h43);
        send(8'hB2, "R9");
        send(8'h01, "R9");
        drain();

        // R8 seven bits, direction ignored
        set_cfg(8'h47);
        send(8'hD3, "R8");
        drain();

        // R7 parity even then odd, good and bad
        set_cfg(8'h0B);
        send(8'h6E, "R7");
        send(8'h6E, "R7", 1'b1);
        set_cfg(8'h1B);
        send(8'h91, "R7");
        send(8'h91, "R7", 1'b1);
        drain();

        // R6 framing error
        set_cfg(8'h03);
        send(8'h77, "R6", 1'b0, 1'b1);
        drain();

        // R10 two stop bits
        set_cfg(8'h23);
        send(8'h4D, "R10");
        drain();
        mon_on = 1'b0;
        drive_bit(1'b0);
        for (int i = 0; i < 8; i++) drive_bit(((8'h99 >> i) & 8'h01) != 0);
        drive_bit(1'b1);
        bus_rd(2'd1, r); chk("R10 not done after first stop", r, 8'h00);
        drive_bit(1'b1);
        bus_rd(2'd1, r); chk("R10 done after second stop", r, 8'h01);
        bus_rd(2'd2, r); chk("R10 data", r, 8'h99);
        bus_wt(2'd1, 8'h00);

        // R2 short low pulse is no start bit
        set_cfg(8'h03);
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        bus_rd(2'd1, r); chk("R2 glitch no flag", r, 8'h00);
        send(8'hC4, "R2", 1'b0, 1'b0, 1'b0);
        bus_rd(2'd2, r); chk("R2 frame after glitch", r, 8'hC4);
        bus_wt(2'd1, 8'h00);

        // R5 overrun, R12 error irq, R11 clear-only semantics
        send(8'h11, "R5", 1'b0, 1'b0, 1'b0);
        send(8'h22, "R5", 1'b0, 1'b0, 1'b0);
        bus_rd(2'd1, r); chk("R5 overrun status", r, 8'h03);
        bus_rd(2'd2, r); chk("R5 data kept", r, 8'h11);
        chk("R12 irqs with errors", {6'b0, irq_rx_full, irq_rx_err}, 8'h03);
        bus_wt(2'd1, 8'h02);
        bus_rd(2'd1, r); chk("R11 keep on 1 clear on 0", r, 8'h02);
        bus_wt(2'd1, 8'hFF);
        bus_rd(2'd1, r); chk("R11 write 1 sets nothing", r, 8'h02);
        bus_wt(2'd1, 8'h00);
        bus_rd(2'd1, r); chk("R11 write 0 clears", r, 8'h00);

        // R12 interrupts masked
        set_cfg(8'h01);
        send(8'h5A, "R12", 1'b0, 1'b0, 1'b0);
        bus_rd(2'd1, r); chk("R12 full set while masked", r, 8'h01);
        chk("R12 irqs masked", {6'b0, irq_rx_full, irq_rx_err}, 8'h00);
        bus_wt(2'd1, 8'h00);

        // R13 receiver disabled
        set_cfg(8'h02);
        send(8'hE7, "R13", 1'b0, 1'b0, 1'b0);
        bus_rd(2'd1, r); chk("R13 no reception when off", r, 8'h00);
        bus_rd(2'd2, r); chk("R13 data unchanged", r, 8'h5A);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule